// File: doc/BRIEF.md
# Late-Write Flow-Through Burst SRAM

This block is a synchronous single-port static memory built for simulation and FPGA use. It accepts one command per clock, read or write, in any mix, and it never needs an idle cycle when the bus turns from reading to writing or back. The address, the chip selects, the write strobe and the load/continue control are sampled on the rising clock edge. Read data comes out combinationally in the cycle that follows the edge that took the address. Write data, with its per-lane enables, is taken one edge later than its address.

A 2-bit beat counter inside the block lets a command run on as a four-beat burst. Each cycle with `advance` high moves to the next address within the aligned group of four, in linear order or in interleaved order. A posted-write register holds the most recent accepted write until the next one arrives. Reads that hit it see its enabled lanes. Depth and lane count are parameters, and each lane is nine bits wide.

Top module: `lw_burst_sram`

## Requirements
- R1: A command is started only at an edge with `stall`=0, `advance`=0, `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. `wr_n`=1 selects a read and `wr_n`=0 selects a write. At an edge with `stall`=0 and `advance`=0 where any select is inactive, the block becomes deselected and `rdata_oe` stays 0.
- R2: At an edge with `stall`=1, every input except `rst_n` and `oe_n` is ignored. Command, burst position and posted write all keep their values.
- R3: After the edge that starts or continues a read, `rdata` carries the word at the current address during that same cycle, with `rdata_oe`=1, provided `oe_n`=0.
- R4: `oe_n` is asynchronous. While it is 1, `rdata_oe`=0 and `rdata`=0. A read cycle with `oe_n`=1 still moves the burst forward (dummy read).
- R5: For every write beat, the data and lane enables present at the edge after that beat's address edge are the ones written.
- R6: At an edge with `stall`=0 and `advance`=1, a read or write in progress moves to its next beat. The selects, `wr_n` and `addr` are ignored at that edge.
- R7: With `order_ilv`=0, beat n uses low address bits (start+n) mod 4. The upper address bits stay fixed, and the sequence returns to the start after four beats.
- R8: With `order_ilv`=1, beat n uses low address bits start XOR n.
- R9: `lane_wr_n` is active low. Bit l guards data bits [9l+8:9l]. Only enabled lanes change.
- R10: A write beat with every `lane_wr_n` bit at 1 is aborted and changes no stored data.
- R11: At an edge with `advance`=1 while the block is deselected, it stays deselected.
- R12: A read of the address held by the posted write returns the posted lanes, merged with the stored lanes that it does not enable.
- R13: At an edge with `rst_n`=0, the block returns to the deselected state with `rdata_oe`=0. Memory contents are kept, including the posted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the command state |
| stall | input | 1 | 1 = ignore this edge |
| advance | input | 1 | 0 = load a new command, 1 = continue the burst |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Word address; its two low bits give the burst start |
| lane_wr_n | input | LANES | Per-lane write enables, active low, taken one edge late |
| wdata | input | LANES*9 | Write data, taken one edge late |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | LANES*9 | Read data, 0 when not driven |
| rdata_oe | output | 1 | 1 while `rdata` is driven |

## Verification
Two functions can fall in the same cycle. A read can target a word whose write data was taken at the very edge that started the read, so the read and the posted-write merge happen together. The bench provokes this by writing a burst and then, in the next command, reading the last written beat. It also issues a write with only some lanes enabled and reads the same address at the edge that takes its data. It judges the result against the word obtained by merging the written lanes with the earlier contents, and checks again after a later write has moved the posted word into the array.

// File: rtl/lw_sram_pkg.sv
// Package: shared types and the burst address rule of the late-write SRAM.
// Assumes bursts are four beats long, over the two low address bits.
package lw_sram_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } cmd_e;

    // Low two address bits for a given beat of a burst.
    function automatic logic [1:0] lw_beat_lsb(input logic [1:0] start,
                                               input logic [1:0] beat,
                                               input logic       ilv);
        return ilv ? (start ^ beat) : 2'(start + beat);
    endfunction

endpackage

// File: rtl/lw_cmd_ctrl.sv
// Command and burst state. Registers the command type and the base address,
// counts beats, and derives the current word address.
// Assumes sel_ok is already the AND of all chip selects.
module lw_cmd_ctrl
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              advance,
    input  logic              sel_ok,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              order_ilv,
    output cmd_e              cmd,
    output logic [ADDR_W-1:0] cur_addr
);

    logic [ADDR_W-1:0] base;
    logic [1:0]        beat;

    // Load a new command, continue a burst or hold on stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd  <= CMD_IDLE;
            base <= '0;
            beat <= 2'd0;
        end else if (!stall) begin
            if (!advance) begin
                if (sel_ok) begin
                    cmd  <= wr_n ? CMD_READ : CMD_WRITE;
                    base <= addr;
                    beat <= 2'd0;
                end else begin
                    cmd  <= CMD_IDLE;
                end
            end else if (cmd != CMD_IDLE) begin
                beat <= 2'(beat + 2'd1);
            end
        end
    end

    // Current address: fixed upper bits, burst-ordered low bits.
    always_comb begin
        cur_addr = {base[ADDR_W-1:2], lw_beat_lsb(base[1:0], beat, order_ilv)};
    end

    assert_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !advance && !sel_ok) |=> cmd == CMD_IDLE);

    assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !advance && sel_ok) |=>
            (cmd == ($past(wr_n) ? CMD_READ : CMD_WRITE)) && beat == 2'd0);

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(cmd) && $stable(base) && $stable(beat));

    assert_continue_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && advance && cmd != CMD_IDLE) |=>
            $stable(cmd) && beat == 2'($past(beat) + 2'd1));

    assert_upper_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && advance && cmd != CMD_IDLE) |=> $stable(cur_addr[ADDR_W-1:2]));

    assert_linear_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && advance && cmd != CMD_IDLE && !order_ilv) |=>
            (order_ilv || cur_addr[1:0] == 2'($past(cur_addr[1:0]) + 2'd1)));

    assert_stay_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && advance && cmd == CMD_IDLE) |=> cmd == CMD_IDLE);

endmodule

// File: rtl/lw_wbuf.sv
// Posted-write register. Takes one write beat's data and lane enables, holds
// them until the next accepted beat or a reset, then hands them to the array.
// Also merges its enabled lanes into a read of the same address.
// Assumes the array writes on the edge where commit_en is high.
module lw_wbuf #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              take,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] arr_word,
    output logic              commit_en,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [DATA_W-1:0] commit_data,
    output logic [LANES-1:0]  commit_lanes,
    output logic [DATA_W-1:0] merged
);

    logic              buf_valid;
    logic [ADDR_W-1:0] buf_addr;
    logic [DATA_W-1:0] buf_data;
    logic [LANES-1:0]  buf_lanes;
    logic              take_any;
    logic              addr_hit;

    // A beat with at least one lane enabled replaces the posted word.
    always_comb begin
        take_any  = take && !stall && (lane_wr_n != {LANES{1'b1}});
        commit_en = buf_valid && (!rst_n || take_any);
        addr_hit  = buf_valid && (buf_addr == cur_addr);
    end

    assign commit_addr  = buf_addr;
    assign commit_data  = buf_data;
    assign commit_lanes = buf_lanes;

    // Posted-word register: cleared by reset (after its flush), loaded on take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_valid <= 1'b0;
        end else if (take_any) begin
            buf_valid <= 1'b1;
            buf_addr  <= cur_addr;
            buf_data  <= wdata;
            buf_lanes <= ~lane_wr_n;
        end
    end

    // Per-lane read merge of the posted word over the stored word.
    for (genvar l = 0; l < LANES; l++) begin : g_merge
        always_comb begin
            merged[l*LANE_W +: LANE_W] = (addr_hit && buf_lanes[l])
                ? buf_data[l*LANE_W +: LANE_W]
                : arr_word[l*LANE_W +: LANE_W];
        end
    end

    assert_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take_any |=> buf_valid && buf_addr == $past(cur_addr)
                     && buf_data == $past(wdata));

    assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !stall && (&lane_wr_n)) |=>
            $stable(buf_valid) && $stable(buf_addr) && $stable(buf_data));

endmodule

// File: rtl/lw_array.sv
// Storage array, one memory per lane so each lane writes on its own.
// One write port driven by the posted-write flush, one combinational read.
// Assumes DEPTH = 2**ADDR_W fits the target's distributed memory.
module lw_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  wlanes,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Lane write from the flushed posted word.
        always_ff @(posedge clk) begin
            if (we && wlanes[l]) begin
                mem[waddr] <= wdata[l*LANE_W +: LANE_W];
            end
        end

        assign rdata[l*LANE_W +: LANE_W] = mem[raddr];
    end

endmodule

// File: rtl/lw_burst_sram.sv
// Top of the late-write flow-through burst SRAM. Joins command control,
// posted-write register and array, and gates read data with the
// asynchronous output enable. Assumes ADDR_W >= 3.
module lw_burst_sram
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    localparam int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              advance,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic [DATA_W-1:0] wdata,
    input  logic              order_ilv,
    input  logic              oe_n,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe
);

    cmd_e              cmd;
    logic [ADDR_W-1:0] cur_addr;
    logic              sel_ok;
    logic [DATA_W-1:0] arr_word;
    logic [DATA_W-1:0] merged;
    logic              commit_en;
    logic [ADDR_W-1:0] commit_addr;
    logic [DATA_W-1:0] commit_data;
    logic [LANES-1:0]  commit_lanes;

    assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

    lw_cmd_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .stall(stall), .advance(advance),
        .sel_ok(sel_ok), .wr_n(wr_n), .addr(addr), .order_ilv(order_ilv),
        .cmd(cmd), .cur_addr(cur_addr)
    );

    lw_wbuf #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) wbuf_i (
        .clk(clk), .rst_n(rst_n), .stall(stall),
        .take(cmd == CMD_WRITE), .cur_addr(cur_addr),
        .lane_wr_n(lane_wr_n), .wdata(wdata), .arr_word(arr_word),
        .commit_en(commit_en), .commit_addr(commit_addr),
        .commit_data(commit_data), .commit_lanes(commit_lanes),
        .merged(merged)
    );

    lw_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) array_i (
        .clk(clk), .we(commit_en), .waddr(commit_addr), .wdata(commit_data),
        .wlanes(commit_lanes), .raddr(cur_addr), .rdata(arr_word)
    );

    // Output gate: drive only during a read cycle with the enable asserted.
    always_comb begin
        rdata_oe = (cmd == CMD_READ) && !oe_n;
        rdata    = rdata_oe ? merged : '0;
    end

    assert_read_flow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!stall && !advance && sel_ok && wr_n) && !oe_n)
            |-> rdata_oe);

    assert_oe_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !rdata_oe && rdata == '0);

    assert_reset_idle_R13: assert property (@(posedge clk)
        !rst_n |=> !rdata_oe);

endmodule

// File: tb/lw_burst_sram_tb_top.sv
module lw_burst_sram_tb_top;

    localparam int AW = 8;
    localparam int LN = 4;
    localparam int DW = LN * 9;

    localparam logic [DW-1:0] D0 = 36'hA_0000_0010;
    localparam logic [DW-1:0] D1 = 36'h1_2345_6789;
    localparam logic [DW-1:0] D2 = 36'h9_8765_4321;
    localparam logic [DW-1:0] D3 = 36'h5_5AA5_5AA0;
    localparam logic [DW-1:0] WW = 36'hF_FFFF_FFFF;
    localparam logic [DW-1:0] MG = 36'h1_27FD_67FF; // D1 with lanes 0,2 from WW
    localparam logic [DW-1:0] E4 = 36'h3_C3C3_C3C3;
    localparam logic [DW-1:0] FF = 36'h7_0707_0707;
    localparam logic [DW-1:0] JK = 36'hD_EADB_EEF1;

    typedef struct packed {
        logic          stall;
        logic          adv;
        logic [1:0]    sel;   // 0 all active, 1 sel_a_n high, 2 sel_b low, 3 sel_c_n high
        logic          wr_n;
        logic [AW-1:0] addr;
        logic [LN-1:0] ln;
        logic [DW-1:0] wd;
        logic          oe_n;
        logic          ilv;
        logic          eoe;
        logic [DW-1:0] edat;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VT [NV] = '{
        '{1'b0,1'b0,2'd0,1'b0,8'h10,4'hF,36'h0,1'b0,1'b0,1'b0,36'h0,4'd5}, // R5 write burst 0x10
        '{1'b0,1'b1,2'd0,1'b1,8'h00,4'h0,D0   ,1'b0,1'b0,1'b0,36'h0,4'd6}, // R6
        '{1'b0,1'b1,2'd0,1'b1,8'h00,4'h0,D1   ,1'b0,1'b0,1'b0,36'h0,4'd6}, // R6
        '{1'b0,1'b1,2'd0,1'b1,8'h00,4'h0,D2   ,1'b0,1'b0,1'b0,36'h0,4'd6}, // R6
        '{1'b0,1'b0,2'd0,1'b1,8'h12,4'h0,D3   ,1'b0,1'b0,1'b1,D2   ,4'd3}, // R3 read 0x12
        '{1'b0,1'b1,2'd0,1'b0,8'h00,4'hF,36'h0,1'b0,1'b0,1'b1,D3   ,4'd12},// R12 posted hit
        '{1'b0,1'b1,2'd0,1'b0,8'h00,4'hF,36'h0,1'b0,1'b0,1'b1,D0   ,4'd7}, // R7 wrap to 0x10
        '{1'b0,1'b1,2'd0,1'b1,8'h00,4'hF,36'h0,1'b0,1'b0,1'b1,D1   ,4'd7}, // R7
        '{1'b0,1'b1,2'd0,1'b1,8'h00,4'hF,36'h0,1'b0,1'b0,1'b1,D2   ,4'd7}, // R7 back at start
        '{1'b0,1'b0,2'd0,1'b1,8'h13,4'hF,36'h0,1'b0,1'b1,1'b1,D3   ,4'd8}, // R8 start 3
        '{1'b0,1'b1,2'd0,1'b1,8'h00,4'hF,36'h0,1'b0,1'b1,1'b1,D2   ,4'd8}, // R8
        '{1'b0,1'b1,2'd0,1'b1,8'h00,4'hF,36'h0,1'b0,1'b1,1'b1,D1   ,4'd8}, // R8
        '{1'b0,1'b1,2'd0,1'b1,8'h00,4'hF,36'h0,1'b0,1'b1,1'b1,D0   ,4'd8}, // R8
        '{1'b0,1'b1,2'd0,1'b1,8'h00,4'hF,36'h0,1'b1,1'b1,1'b0,36'h0,4'd4}, // R4 dummy read
        '{1'b0,1'b1,2'd0,1'b1,8'h00,4'hF,36'h0,1'b0,1'b1,1'b1,D2   ,4'd4}, // R4 advanced
        '{1'b0,1'b0,2'd2,1'b1,8'h10,4'hF,36'h0,1'b0,1'b0,1'b0,36'h0,4'd1}, // R1 sel_b low
        '{1'b0,1'b1,2'd0,1'b1,8'h10,4'hF,36'h0,1'b0,1'b0,1'b0,36'h0,4'd11},// R11
        '{1'b0,1'b0,2'd0,1'b1,8'h10,4'hF,36'h0,1'b0,1'b0,1'b1,D0   ,4'd3}, // R3
        '{1'b1,1'b0,2'd0,1'b0,8'h55,4'hF,36'h0,1'b0,1'b0,1'b1,D0   ,4'd2}, // R2 stalled edge
        '{1'b0,1'b1,2'd0,1'b1,8'h00,4'hF,36'h0,1'b0,1'b0,1'b1,D1   ,4'd2}, // R2
        '{1'b0,1'b0,2'd0,1'b0,8'h11,4'hF,36'h0,1'b0,1'b0,1'b0,36'h0,4'd5}, // R5 write 0x11
        '{1'b0,1'b0,2'd0,1'b1,8'h11,4'hA,WW   ,1'b0,1'b0,1'b1,MG   ,4'd9}, // R9 lanes 0,2
        '{1'b0,1'b0,2'd0,1'b0,8'h12,4'hF,36'h0,1'b0,1'b0,1'b0,36'h0,4'd10},// R10 write 0x12
        '{1'b0,1'b0,2'd0,1'b1,8'h12,4'hF,JK   ,1'b0,1'b0,1'b1,D2   ,4'd10},// R10 aborted
        '{1'b0,1'b0,2'd0,1'b0,8'h14,4'hF,36'h0,1'b0,1'b0,1'b0,36'h0,4'd5}, // R5 write 0x14
        '{1'b1,1'b1,2'd0,1'b1,8'h00,4'h0,JK   ,1'b0,1'b0,1'b0,36'h0,4'd2}, // R2 data ignored
        '{1'b0,1'b0,2'd0,1'b1,8'h14,4'h0,E4   ,1'b0,1'b0,1'b1,E4   ,4'd5}, // R5
        '{1'b0,1'b0,2'd3,1'b1,8'h10,4'hF,36'h0,1'b0,1'b0,1'b0,36'h0,4'd1}, // R1 sel_c_n high
        '{1'b0,1'b0,2'd1,1'b1,8'h10,4'hF,36'h0,1'b0,1'b0,1'b0,36'h0,4'd1}, // R1 sel_a_n high
        '{1'b0,1'b0,2'd0,1'b1,8'h11,4'hF,36'h0,1'b0,1'b0,1'b1,MG   ,4'd9}  // R9 after flush
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stall = 1'b0, advance = 1'b0, sel_a_n = 1'b1, sel_b = 1'b1, sel_c_n = 1'b0;
    logic          wr_n = 1'b1, order_ilv = 1'b0, oe_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [LN-1:0] lane_wr_n = '1;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_oe;
    int            n_chk = 0;
    int            n_bad = 0;
    logic          done = 1'b0;

    always #5 clk = ~clk;

    lw_burst_sram #(.ADDR_W(AW), .LANES(LN)) dut_i (
        .clk(clk), .rst_n(rst_n), .stall(stall), .advance(advance),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .wr_n(wr_n),
        .addr(addr), .lane_wr_n(lane_wr_n), .wdata(wdata),
        .order_ilv(order_ilv), .oe_n(oe_n), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    task automatic check(input string req, input logic eoe, input logic [DW-1:0] edat);
        n_chk++;
        if (rdata_oe !== eoe) begin
            n_bad++;
            $display("FAIL %s rdata_oe actual %0b expected %0b", req, rdata_oe, eoe);
        end
        n_chk++;
        if (rdata !== edat) begin
            n_bad++;
            $display("FAIL %s rdata actual %h expected %h", req, rdata, edat);
        end
    endtask

    // Drive at the falling edge, then sample 2 ns after the rising edge.
    task automatic step(input logic st, input logic adv, input logic [1:0] sel,
                        input logic wn, input logic [AW-1:0] a, input logic [LN-1:0] ln,
                        input logic [DW-1:0] wd, input logic oe, input logic ilv);
        @(negedge clk);
        stall = st; advance = adv; wr_n = wn; addr = a; lane_wr_n = ln;
        wdata = wd; oe_n = oe; order_ilv = ilv;
        sel_a_n = (sel == 2'd1); sel_b = (sel != 2'd2); sel_c_n = (sel == 2'd3);
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        // R13: reset state
        step(1'b0, 1'b0, 2'd0, 1'b1, 8'h10, 4'hF, '0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 2'd0, 1'b1, 8'h10, 4'hF, '0, 1'b0, 1'b0);
        check("R13", 1'b0, '0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VT[i].stall, VT[i].adv, VT[i].sel, VT[i].wr_n, VT[i].addr,
                 VT[i].ln, VT[i].wd, VT[i].oe_n, VT[i].ilv);
            check($sformatf("R%0d vec%0d", VT[i].req, i), VT[i].eoe, VT[i].edat);
        end

        // R13: reset in the middle of a write burst keeps the posted word
        step(1'b0, 1'b0, 2'd0, 1'b0, 8'h20, 4'hF, '0, 1'b0, 1'b0);
        check("R13 write 0x20", 1'b0, '0);
        step(1'b0, 1'b1, 2'd0, 1'b1, 8'h00, 4'h0, FF, 1'b0, 1'b0);
        check("R13 beat data", 1'b0, '0);
        @(negedge clk); rst_n = 1'b0;
        step(1'b0, 1'b1, 2'd0, 1'b1, 8'h00, 4'h0, JK, 1'b0, 1'b0);
        check("R13 in reset", 1'b0, '0);
        @(negedge clk); rst_n = 1'b1;
        step(1'b0, 1'b1, 2'd0, 1'b1, 8'h00, 4'hF, '0, 1'b0, 1'b0);
        check("R13 idle after reset", 1'b0, '0);
        step(1'b0, 1'b0, 2'd0, 1'b1, 8'h20, 4'hF, '0, 1'b0, 1'b0);
        check("R13 posted kept", 1'b1, FF);
        step(1'b0, 1'b0, 2'd0, 1'b1, 8'h14, 4'hF, '0, 1'b0, 1'b0);
        check("R13 memory kept", 1'b1, E4);
        step(1'b0, 1'b0, 2'd0, 1'b1, 8'h10, 4'hF, '0, 1'b0, 1'b0);
        check("R3 read 0x10", 1'b1, D0);

        // R4: output enable acts without a clock edge
        oe_n = 1'b1;
        #1;
        check("R4 oe_n high", 1'b0, '0);
        oe_n = 1'b0;
        #1;
        check("R4 oe_n low", 1'b1, D0);

        done = 1'b1;
        finish_run();
    end

endmodule